// File: doc/BRIEF.md
# Pipelined AES-128 Block Encryptor

This block encrypts 128-bit data blocks with AES-128 at a rate of one block per clock. The cipher is fully unrolled. An input stage performs the whitening XOR with the cipher key. Ten round stages follow, and each round stage holds one register. A new block and its own 128-bit key can be presented on every clock. After the pipeline fills, one ciphertext leaves on every clock, in the order the blocks entered.

The round keys are not precomputed and kept in a table. Each stage carries the round key it has just used together with the data. The next stage derives its own round key from that key in the same cycle in which it processes the data. Because of this, every block in flight has its own key, and the key may change from one cycle to the next at no cost. The substitution step indexes a 256-entry byte table. The table's contents are computed when the design is elaborated.

A single valid bit travels down the pipe beside the data. A synchronous reset clears every valid bit. The data registers have no reset.

Top module: `aes128_pipe`

## Requirements
- R1: `out_block` is the AES-128 encryption of the captured `in_block` under the captured `in_key`. The byte order is as follows. Bits [127:120] hold byte 0. Byte n sits at bits [127-8n -: 8]. Bytes fill the 4x4 state column by column, so byte n is at row n%4 and column n/4. The key words use the same layout.
- R2: A block sampled on a rising edge with `in_valid` high appears on `out_valid`/`out_block` after exactly 11 rising edges, counting the sampling edge.
- R3: Blocks presented on consecutive cycles leave on consecutive cycles, in order, with no bubble between them.
- R4: The key is sampled with each block, so neighbouring blocks with different keys are each encrypted under their own key.
- R5: `out_valid` is low exactly in the cycles where the input slot 11 edges earlier carried `in_valid` low. Gaps in the input stream reappear unchanged at the output.
- R6: A rising edge with `rst` high clears every valid bit. Blocks already in flight never emerge. `out_valid` stays low until blocks sampled after the reset reach the end of the pipe.
- R7: The result is correct for each of the 256 byte values when that value fills every state byte and the key is also built from repeated bytes.
- R8: The same block under the same key gives the same ciphertext no matter which blocks surround it in the pipe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears valid bits |
| in_valid | input | 1 | Qualifies in_block and in_key on this edge |
| in_block | input | 128 | Plaintext block, byte 0 in the top bits |
| in_key | input | 128 | Cipher key for this block, byte 0 in the top bits |
| out_valid | output | 1 | out_block holds a finished ciphertext |
| out_block | output | 128 | Ciphertext, same byte order as in_block |

## Verification
The bound checker watches the valid timing on every cycle. It checks that a reset clears the output, that nothing leaves while the pipe refills after reset, and that `out_valid` follows `in_valid` with a lag of exactly eleven edges. It also checks that two identical block/key pairs fed one after the other give two identical ciphertexts. The cipher values themselves can only be shown by the bench's scenarios. These cover two published known-answer vectors, a sweep over all 256 repeated-byte values, a new random key on every cycle, a randomly gapped stream, and a reset that drops blocks in flight. Each expected value comes from a behavioural model in the bench, whose S-box is built from field inversion.

// File: rtl/aes128_pkg.sv
package aes128_pkg;

   localparam int BLOCK_BITS = 128;
   localparam int KEY_BITS   = 128;
   localparam int NUM_ROUNDS = 10;
   localparam int BYTE_BITS  = 8;
   localparam int NUM_BYTES  = BLOCK_BITS / BYTE_BITS;
   localparam int WORD_BITS  = 32;

   typedef logic [BYTE_BITS-1:0]   byte_t;
   typedef logic [WORD_BITS-1:0]   word_t;
   typedef logic [BLOCK_BITS-1:0]  block_t;
   typedef logic [255:0][7:0]      sbox_tab_t;

   // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
   function automatic byte_t gf_dbl(input byte_t b);
      return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
   endfunction

   // round constant for round r (r >= 1)
   function automatic byte_t round_const(input int r);
      byte_t x;
      x = 8'h01;
      for (int i = 1; i < r; i++) x = gf_dbl(x);
      return x;
   endfunction

   // substitution table: inverse via exp/log over generator 3, then affine map
   function automatic sbox_tab_t sbox_build();
      sbox_tab_t pw, lg, tab;
      byte_t     x, inv;
      pw  = '0;
      lg  = '0;
      tab = '0;
      x   = 8'h01;
      for (int i = 0; i < 255; i++) begin
         pw[8'(i)] = x;
         lg[x]     = 8'(i);
         x         = x ^ gf_dbl(x);
      end
      for (int v = 0; v < 256; v++) begin
         if (v == 0) inv = 8'h00;
         else        inv = pw[8'((255 - int'(lg[8'(v)])) % 255)];
         tab[8'(v)] = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                      ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
      end
      return tab;
   endfunction

   localparam sbox_tab_t SBOX_TAB = sbox_build();

endpackage

// File: rtl/aes128_sbox.sv
module aes128_sbox
   import aes128_pkg::*;
(
   input  logic [7:0] d,
   output logic [7:0] q
);
   assign q = SBOX_TAB[d];
endmodule

// File: rtl/aes128_mixcol.sv
module aes128_mixcol
   import aes128_pkg::*;
#(
   parameter int COL_BYTES = 4
) (
   input  logic [COL_BYTES*8-1:0] col_i,
   output logic [COL_BYTES*8-1:0] col_o
);
   localparam int CW = COL_BYTES * 8;

   if (COL_BYTES != 4) begin : g_bad_cfg
      $error("aes128_mixcol: column must hold four bytes");
   end

   byte_t b [COL_BYTES];

   for (genvar i = 0; i < COL_BYTES; i++) begin : g_unpack
      assign b[i] = col_i[CW-1-8*i -: 8];
   end

   // row i of the circulant {02 03 01 01}
   for (genvar i = 0; i < COL_BYTES; i++) begin : g_row
      localparam int I1 = (i + 1) % COL_BYTES;
      localparam int I2 = (i + 2) % COL_BYTES;
      localparam int I3 = (i + 3) % COL_BYTES;
      assign col_o[CW-1-8*i -: 8] = gf_dbl(b[i]) ^ gf_dbl(b[I1]) ^ b[I1]
                                    ^ b[I2] ^ b[I3];
   end
endmodule

// File: rtl/aes128_round.sv
module aes128_round
   import aes128_pkg::*;
#(
   parameter bit LAST = 1'b0
) (
   input  logic [BLOCK_BITS-1:0] st_i,
   input  logic [BLOCK_BITS-1:0] rk_i,
   output logic [BLOCK_BITS-1:0] st_o
);
   localparam int ROWS = 4;
   localparam int COLS = NUM_BYTES / ROWS;
   localparam int TOP  = BLOCK_BITS - 1;

   block_t sub_w, shf_w, mix_w;

   for (genvar i = 0; i < NUM_BYTES; i++) begin : g_sub
      aes128_sbox u_sb (
         .d (st_i[TOP-8*i -: 8]),
         .q (sub_w[TOP-8*i -: 8])
      );
   end

   // row r rotates left by r bytes
   for (genvar c = 0; c < COLS; c++) begin : g_shc
      for (genvar r = 0; r < ROWS; r++) begin : g_shr
         localparam int SRC = ROWS * ((c + r) % COLS) + r;
         assign shf_w[TOP-8*(ROWS*c+r) -: 8] = sub_w[TOP-8*SRC -: 8];
      end
   end

   if (LAST) begin : g_final
      assign mix_w = shf_w;
   end else begin : g_full
      for (genvar c = 0; c < COLS; c++) begin : g_mc
         aes128_mixcol #(.COL_BYTES(ROWS)) u_mc (
            .col_i (shf_w[TOP-32*c -: 32]),
            .col_o (mix_w[TOP-32*c -: 32])
         );
      end
   end

   assign st_o = mix_w ^ rk_i;
endmodule

// File: rtl/aes128_keystep.sv
module aes128_keystep
   import aes128_pkg::*;
#(
   parameter logic [7:0] RC = 8'h01
) (
   input  logic [KEY_BITS-1:0] rk_i,
   output logic [KEY_BITS-1:0] rk_o
);
   localparam int NW = KEY_BITS / WORD_BITS;

   if (NW != 4) begin : g_bad_cfg
      $error("aes128_keystep: only a four-word key is supported");
   end

   word_t w [NW];
   word_t n [NW];
   word_t rot_w, sub_w;

   for (genvar i = 0; i < NW; i++) begin : g_words
      assign w[i] = rk_i[KEY_BITS-1-WORD_BITS*i -: WORD_BITS];
      assign rk_o[KEY_BITS-1-WORD_BITS*i -: WORD_BITS] = n[i];
   end

   assign rot_w = {w[NW-1][23:0], w[NW-1][31:24]};

   for (genvar j = 0; j < 4; j++) begin : g_sub
      aes128_sbox u_sb (
         .d (rot_w[31-8*j -: 8]),
         .q (sub_w[31-8*j -: 8])
      );
   end

   assign n[0] = w[0] ^ sub_w ^ {RC, 24'h000000};
   for (genvar i = 1; i < NW; i++) begin : g_chain
      assign n[i] = w[i] ^ n[i-1];
   end
endmodule

// File: rtl/aes128_pipe.sv
module aes128_pipe
   import aes128_pkg::*;
#(
   parameter int BLOCK_W = 128,
   parameter int KEY_W   = 128,
   parameter int ROUNDS  = 10
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_valid,
   input  logic [BLOCK_W-1:0] in_block,
   input  logic [KEY_W-1:0]   in_key,
   output logic               out_valid,
   output logic [BLOCK_W-1:0] out_block
);
   localparam int STAGES = ROUNDS + 1;

   if (BLOCK_W != BLOCK_BITS) begin : g_bad_blk
      $error("aes128_pipe: block width must be 128");
   end
   if (KEY_W != KEY_BITS) begin : g_bad_key
      $error("aes128_pipe: key width must be 128");
   end
   if (ROUNDS != NUM_ROUNDS) begin : g_bad_rnd
      $error("aes128_pipe: AES-128 needs ten rounds");
   end

   logic [STAGES-1:0]  vld_q;
   logic [BLOCK_W-1:0] st_q    [STAGES];
   logic [KEY_W-1:0]   key_q   [ROUNDS];
   logic [BLOCK_W-1:0] st_d    [ROUNDS];
   logic [KEY_W-1:0]   rk_next [ROUNDS];

   for (genvar r = 1; r <= ROUNDS; r++) begin : g_stage
      aes128_keystep #(.RC(round_const(r))) u_ks (
         .rk_i (key_q[r-1]),
         .rk_o (rk_next[r-1])
      );
      aes128_round #(.LAST(r == ROUNDS)) u_rd (
         .st_i (st_q[r-1]),
         .rk_i (rk_next[r-1]),
         .st_o (st_d[r-1])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) vld_q <= '0;
      else     vld_q <= {vld_q[STAGES-2:0], in_valid};
   end

   // data registers load only behind a valid bit, and have no reset
   always_ff @(posedge clk) begin
      if (in_valid) begin
         st_q[0]  <= in_block ^ in_key;
         key_q[0] <= in_key;
      end
      for (int r = 1; r <= ROUNDS; r++) begin
         if (vld_q[r-1]) st_q[r] <= st_d[r-1];
      end
      for (int r = 1; r < ROUNDS; r++) begin
         if (vld_q[r-1]) key_q[r] <= rk_next[r-1];
      end
   end

   assign out_valid = vld_q[STAGES-1];
   assign out_block = st_q[STAGES-1];
endmodule

// File: rtl/aes128_pipe_chk.sv
module aes128_pipe_chk (
   input logic         clk,
   input logic         rst,
   input logic         in_valid,
   input logic [127:0] in_block,
   input logic [127:0] in_key,
   input logic         out_valid,
   input logic [127:0] out_block
);
   localparam int LAT = 11;
   localparam int SAT = LAT + 1;

   logic [3:0] since_rst;

   always_ff @(posedge clk) begin
      if (rst)                  since_rst <= '0;
      else if (since_rst < SAT) since_rst <= since_rst + 4'd1;
   end

   // R6: a reset edge leaves no valid output behind it
   a_r6_reset_clears_valid: assert property (@(posedge clk)
      $past(rst) |-> !out_valid);

   // R6: nothing leaves while the pipe refills after reset
   a_r6_quiet_refill: assert property (@(posedge clk) disable iff (rst)
      (since_rst < 4'(LAT)) |-> !out_valid);

   // R2 / R5: output valid is the input valid eleven edges late
   a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
      (since_rst >= 4'(LAT)) |-> (out_valid == $past(in_valid, 11)));

   // R8: equal neighbouring inputs give equal neighbouring outputs
   a_r8_repeat_same_result: assert property (@(posedge clk) disable iff (rst)
      ((since_rst >= 4'(SAT)) && out_valid && $past(out_valid)
       && ($past(in_block, 11) == $past(in_block, 12))
       && ($past(in_key, 11) == $past(in_key, 12)))
      |-> $stable(out_block));
endmodule

bind aes128_pipe aes128_pipe_chk u_chk (.*);

// File: tb/aes128_pipe_tb.sv
module aes128_pipe_tb;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic [127:0] in_block = '0;
   logic [127:0] in_key = '0;
   logic         out_valid;
   logic [127:0] out_block;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   logic [31:0] seed = 32'h1234_abcd;

   logic [7:0] tb_sb [256];

   logic         hv   [16];
   logic [127:0] hexp [16];
   string        htag [16];

   always #2.5 clk = ~clk;

   aes128_pipe u_dut (
      .clk (clk), .rst (rst), .in_valid (in_valid),
      .in_block (in_block), .in_key (in_key),
      .out_valid (out_valid), .out_block (out_block)
   );

   function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] p = 8'h00;
      logic [7:0] aa = a;
      logic [7:0] bb = b;
      for (int i = 0; i < 8; i++) begin
         if (bb[0]) p = p ^ aa;
         aa = aa[7] ? ((aa << 1) ^ 8'h1b) : (aa << 1);
         bb = bb >> 1;
      end
      return p;
   endfunction

   task automatic build_sbox();
      for (int a = 0; a < 256; a++) begin
         logic [7:0] inv = 8'h00;
         logic [7:0] y;
         for (int b = 1; b < 256; b++)
            if (a != 0 && gmul(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
         y = 8'h63;
         for (int k = 0; k < 5; k++)
            y = y ^ ((inv << k) | (inv >> (8 - k)));
         tb_sb[a] = y;
      end
   endtask

   function automatic logic [127:0] model(input logic [127:0] pt, input logic [127:0] key);
      logic [31:0] w [44];
      logic [7:0]  s [16];
      logic [7:0]  t [16];
      logic [7:0]  rc = 8'h01;
      logic [127:0] res;
      for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
      for (int i = 4; i < 44; i++) begin
         logic [31:0] tmp = w[i-1];
         if (i % 4 == 0) begin
            tmp = {tb_sb[tmp[23:16]] ^ rc, tb_sb[tmp[15:8]], tb_sb[tmp[7:0]], tb_sb[tmp[31:24]]};
            rc = gmul(rc, 8'h02);
         end
         w[i] = w[i-4] ^ tmp;
      end
      for (int i = 0; i < 16; i++)
         s[i] = pt[127-8*i -: 8] ^ w[i/4][31-8*(i%4) -: 8];
      for (int rnd = 1; rnd <= 10; rnd++) begin
         for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
               t[4*c+r] = tb_sb[s[4*((c+r)%4)+r]];
         for (int c = 0; c < 4; c++) begin
            logic [7:0] a0 = t[4*c];
            logic [7:0] a1 = t[4*c+1];
            logic [7:0] a2 = t[4*c+2];
            logic [7:0] a3 = t[4*c+3];
            if (rnd < 10) begin
               t[4*c]   = gmul(a0,2) ^ gmul(a1,3) ^ a2 ^ a3;
               t[4*c+1] = a0 ^ gmul(a1,2) ^ gmul(a2,3) ^ a3;
               t[4*c+2] = a0 ^ a1 ^ gmul(a2,2) ^ gmul(a3,3);
               t[4*c+3] = gmul(a0,3) ^ a1 ^ a2 ^ gmul(a3,2);
            end
         end
         for (int i = 0; i < 16; i++)
            s[i] = t[i] ^ w[4*rnd + i/4][31-8*(i%4) -: 8];
      end
      for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
      return res;
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
      end
   endtask

   function automatic logic [31:0] rnd32();
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      return seed;
   endfunction

   function automatic logic [127:0] rnd128();
      return {rnd32(), rnd32(), rnd32(), rnd32()};
   endfunction

   // one clock slot: check the output, then drive this slot's inputs
   task automatic step(input logic v, input logic [127:0] b, input logic [127:0] k,
                       input logic [127:0] exp, input string tag, input logic r);
      int old;
      @(negedge clk);
      old = (cyc + 5) % 16;
      if (hv[old]) begin
         check(out_valid == 1'b1, htag[old], "out_valid", {127'd0, out_valid}, 128'd1);
         check(out_block == hexp[old], htag[old], "out_block", out_block, hexp[old]);
      end else begin
         check(out_valid == 1'b0, htag[old], "out_valid idle", {127'd0, out_valid}, 128'd0);
      end
      rst      = r;
      in_valid = v;
      in_block = b;
      in_key   = k;
      if (r) begin
         for (int i = 0; i < 16; i++) begin
            hv[i]   = 1'b0;
            htag[i] = "R6";
         end
      end
      hv[cyc % 16]   = v && !r;
      hexp[cyc % 16] = exp;
      htag[cyc % 16] = tag;
      cyc++;
   endtask

   task automatic send(input logic [127:0] b, input logic [127:0] k, input string tag);
      step(1'b1, b, k, model(b, k), tag, 1'b0);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, '0, '0, '0, tag, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) begin
         hv[i]   = 1'b0;
         hexp[i] = '0;
         htag[i] = "R6";
      end
      build_sbox();

      // R6: reset state, with in_valid high during reset ignored
      for (int i = 0; i < 3; i++) step(1'b1, '1, '1, '0, "R6", 1'b1);
      idle(2, "R6");

      // R1: published known-answer vectors, back to back
      step(1'b1, 128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f,
           128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R1", 1'b0);
      step(1'b1, 128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c,
           128'h3925841d02dc09fbdc118597196a0b32, "R1", 1'b0);
      check(model(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f)
            == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R1", "bench model",
            model(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f),
            128'h69c4e0d86a7b0430d8cdb78070b4c55a);

      // R2: a lone block, surrounded by idle slots
      idle(3, "R5");
      send(128'hfedcba9876543210_0123456789abcdef, 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0, "R2");
      idle(14, "R5");

      // R7: every repeated-byte value, streamed back to back
      for (int v = 0; v < 256; v++)
         send({16{8'(v)}}, {16{8'(v * 7 + 3)}}, "R7");

      // R3: counter-style stream under one key
      for (int i = 0; i < 30; i++)
         send(128'h0123_4567_89ab_cdef_0000_0000_0000_0000 + 128'(i),
              128'h2b7e151628aed2a6abf7158809cf4f3c, "R3");

      // R4: new random key every cycle
      for (int i = 0; i < 64; i++) send(rnd128(), rnd128(), "R4");

      // R5: randomly gapped stream
      for (int i = 0; i < 60; i++) begin
         if (rnd32() % 3 != 0) send(rnd128(), rnd128(), "R5");
         else idle(1, "R5");
      end

      // R8: one block/key pair repeated
      for (int i = 0; i < 20; i++)
         send(128'hdeadbeef_cafef00d_01020304_a5a5a5a5, 128'h55aa55aa_00ff00ff_13579bdf_2468ace0, "R8");

      // R6: reset while blocks are in flight
      for (int i = 0; i < 6; i++) send(rnd128(), rnd128(), "R3");
      step(1'b1, rnd128(), rnd128(), '0, "R6", 1'b1);
      step(1'b0, '0, '0, '0, "R6", 1'b1);
      idle(14, "R6");
      for (int i = 0; i < 5; i++) send(rnd128(), rnd128(), "R6");
      idle(14, "R5");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule